// File: doc/BRIEF.md
# Unsigned Divider with HI/LO Result Registers

This block is the unsigned integer divide unit of a small in-order processor core, together with the pair of result registers that a divide fills and the two move-from instructions that read them. The core presents one instruction word per cycle along with the two source register values it has already fetched. The block picks out the words it owns and ignores all others. An unsigned divide word starts a restoring division that yields one quotient bit per cycle. When it finishes, the remainder goes to HI and the quotient goes to LO.

A move-from-HI or move-from-LO word makes the block return the selected register on a registered write-back port one cycle later. The port carries the destination register number taken from the instruction. While a division is running the block holds `busy` high. A read presented during that time is not answered, and the pipeline must present it again once `busy` has fallen. A divide presented while another is still running abandons the first one and starts over. A zero divisor needs no special handling and raises no trap: the division simply runs to its natural result.

Top module: `hilo_divider`

## Requirements
- R1: After a synchronous active-low reset, HI and LO hold zero, `busy` is low and `wb_valid` is low.
- R2: The block accepts an unsigned divide when `instr_valid` is high and the word has opcode bits 31:26 = 0, function bits 5:0 = 0x1B and bits 15:6 = 0. The rs field is in bits 25:21 and the rt field is in bits 20:16, so for example 0x0107001B is a divide of rs=8 by rt=7. The dividend is taken from `rs_data` and the divisor from `rt_data`.
- R3: A read requires opcode 0, bits 25:16 = 0 and bits 10:6 = 0. Function 0x10 reads HI and function 0x12 reads LO, with the destination in bits 15:11; for example 0x00004012 reads LO into register 8. The result appears on `wb_valid`, `wb_addr` and `wb_data` in the cycle after the read is accepted.
- R4: A completed divide leaves the dividend modulo the divisor in HI and the integer quotient in LO.
- R5: A divide by zero completes normally and leaves LO all ones and HI equal to the dividend.
- R6: `busy` is high for exactly DATA_W cycles after the cycle in which a divide is accepted. A read presented in the first cycle with `busy` low returns the new result.
- R7: A read presented while `busy` is high produces no write-back, and it leaves HI and LO unchanged.
- R8: A read whose destination field is 0 produces no write-back.
- R9: A divide accepted while `busy` is high abandons the running one. `busy` then stays high for DATA_W cycles counted from the new divide, and HI/LO receive only the new result.
- R10: A read followed in the very next cycle by a divide returns the value held before that divide.
- R11: Words that match none of the encodings above have no effect on `busy`, HI, LO or the write-back port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | `instr` holds an instruction in this cycle |
| instr | input | 32 | Instruction word |
| rs_data | input | DATA_W | Value of the rs register (dividend) |
| rt_data | input | DATA_W | Value of the rt register (divisor) |
| busy | output | 1 | Division in progress; reads are stalled |
| wb_valid | output | 1 | Write-back of a HI/LO read this cycle |
| wb_addr | output | 5 | Destination register of the write-back |
| wb_data | output | DATA_W | Value read from HI or LO |

## Verification
Two functions can fall in the same cycle: the registered write-back of a read, and the loading of a new divide presented immediately after that read. The bench provokes this by driving a read of LO and then a divide with fresh operands on the next cycle. It then checks that the write-back carries the LO value from before the divide, and that `busy` rises at the same time. A related overlap arises when a new divide lands while the previous one is still stepping. That case is judged by the length of the `busy` window and by the result that is finally read back. Around these cases, every operand pair of a 6-bit configuration, the zero divisor included, is compared against quotient and remainder computed in the bench.

// File: rtl/hilo_div_pkg.sv
// Shared encodings and command type for the HI/LO divide unit.
// Assumes 32-bit instruction words with a 6-bit opcode at the top
// and a 6-bit function field at the bottom.
package hilo_div_pkg;

    localparam int unsigned INSTR_W = 32;
    localparam int unsigned REG_W   = 5;

    localparam logic [5:0] OPC_SPECIAL = 6'h00;
    localparam logic [5:0] FN_DIVU     = 6'h1B;
    localparam logic [5:0] FN_RD_HI    = 6'h10;
    localparam logic [5:0] FN_RD_LO    = 6'h12;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_DIV,
        CMD_RD_HI,
        CMD_RD_LO
    } hilo_op_e;

    typedef struct packed {
        hilo_op_e         op;
        logic [REG_W-1:0] dest;
    } hilo_cmd_t;

endpackage

// File: rtl/hilo_decode.sv
// Instruction decoder for the divide unit.
// Turns a raw instruction word into a command. Any word that is not an
// exact divide or move-from encoding becomes CMD_NONE.
// Assumes: purely combinational; the caller qualifies the result by time.
module hilo_decode
    import hilo_div_pkg::*;
(
    input  logic               valid_i,
    input  logic [INSTR_W-1:0] word_i,
    output hilo_cmd_t          cmd_o
);

    logic [5:0] opc;
    logic [5:0] fn;
    logic       div_shape;
    logic       rd_shape;

    assign opc       = word_i[31:26];
    assign fn        = word_i[5:0];
    assign div_shape = (word_i[15:6] == 10'd0);
    assign rd_shape  = (word_i[25:16] == 10'd0) && (word_i[10:6] == 5'd0);

    // Purpose: classify the word and extract the destination field.
    always_comb begin
        cmd_o.op   = CMD_NONE;
        cmd_o.dest = word_i[15:11];
        if (valid_i && opc == OPC_SPECIAL) begin
            if (fn == FN_DIVU && div_shape) begin
                cmd_o.op = CMD_DIV;
            end else if (fn == FN_RD_HI && rd_shape) begin
                cmd_o.op = CMD_RD_HI;
            end else if (fn == FN_RD_LO && rd_shape) begin
                cmd_o.op = CMD_RD_LO;
            end
        end
    end

endmodule

// File: rtl/div_seq.sv
// Step sequencer for the iterative divider.
// Counts STEPS cycles after a start. A start while running restarts
// the count.
// Assumes: STEPS >= 2.
module div_seq #(
    parameter int unsigned STEPS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic running_o,
    output logic last_o
);

    localparam int unsigned CNT_W = (STEPS > 2) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEPS - 1);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: run flag and step counter, with start taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_o <= 1'b0;
            cnt_q     <= '0;
        end else if (start_i) begin
            running_o <= 1'b1;
            cnt_q     <= '0;
        end else if (running_o) begin
            if (cnt_q == CNT_LAST) begin
                running_o <= 1'b0;
                cnt_q     <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign last_o = running_o && (cnt_q == CNT_LAST);

    // R6: a run ends only after its final step, never on a restart
    a_r6_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running_o) |-> ($past(cnt_q) == CNT_LAST) && !$past(start_i));

endmodule

// File: rtl/div_step_path.sv
// Restoring division datapath.
// Each step shifts one dividend bit into the partial remainder and
// subtracts the divisor when that does not borrow. The step results are
// also exposed unregistered so that the final step can be committed
// directly.
// Assumes: W >= 2; step_i is ignored in a cycle where start_i is high.
module div_step_path #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         step_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] rem_next_o,
    output logic [W-1:0] quo_next_o
);

    logic [W-1:0] rem_q;
    logic [W-1:0] quo_q;
    logic [W-1:0] dvs_q;
    logic [W:0]   shifted;
    logic [W:0]   diff;
    logic         take;

    // Purpose: one restoring step computed from the current state.
    always_comb begin
        shifted    = {rem_q, quo_q[W-1]};
        diff       = shifted - {1'b0, dvs_q};
        take       = ~diff[W];
        rem_next_o = take ? diff[W-1:0] : shifted[W-1:0];
        quo_next_o = {quo_q[W-2:0], take};
    end

    // Purpose: load operands on start and advance one bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
        end else if (start_i) begin
            rem_q <= '0;
            quo_q <= dividend_i;
            dvs_q <= divisor_i;
        end else if (step_i) begin
            rem_q <= rem_next_o;
            quo_q <= quo_next_o;
        end
    end

    // R4: each partial remainder stays below a nonzero divisor
    a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !start_i && dvs_q != '0) |-> (rem_next_o < dvs_q));

endmodule

// File: rtl/hilo_file.sv
// HI/LO result registers and the registered read write-back.
// HI takes the remainder and LO the quotient on commit. A read captures
// the selected register at the edge where it is accepted, so a later
// commit cannot change a value already read.
// Assumes: commit_i and rd_en_i are never high together.
module hilo_file #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit_i,
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic         rd_en_i,
    input  logic         rd_hi_i,
    input  logic [4:0]   rd_dest_i,
    output logic         wb_valid_o,
    output logic [4:0]   wb_addr_o,
    output logic [W-1:0] wb_data_o
);

    logic [W-1:0] hi_q;
    logic [W-1:0] lo_q;

    // Purpose: hold the last committed remainder and quotient.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (commit_i) begin
            hi_q <= rem_i;
            lo_q <= quo_i;
        end
    end

    // Purpose: register the write-back, dropping destination 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid_o <= 1'b0;
            wb_addr_o  <= '0;
            wb_data_o  <= '0;
        end else begin
            wb_valid_o <= rd_en_i && (rd_dest_i != 5'd0);
            wb_addr_o  <= rd_dest_i;
            wb_data_o  <= rd_hi_i ? hi_q : lo_q;
        end
    end

    // R8: register 0 is never the target of a write-back
    a_r8_no_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> (wb_addr_o != 5'd0));

    // R7: HI and LO change only on a commit
    a_r7_hilo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> ($stable(hi_q) && $stable(lo_q)));

endmodule

// File: rtl/hilo_divider.sv
// Top level of the unsigned divide unit with HI/LO.
// Decodes the instruction, runs the divider for DATA_W cycles, commits
// the result and answers HI/LO reads when no division is running.
// Assumes: one instruction per cycle; the pipeline re-presents a read
// that was stalled by busy.
module hilo_divider
    import hilo_div_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] rs_data,
    input  logic [DATA_W-1:0] rt_data,
    output logic              busy,
    output logic              wb_valid,
    output logic [4:0]        wb_addr,
    output logic [DATA_W-1:0] wb_data
);

    hilo_cmd_t         cmd;
    logic              start;
    logic              running;
    logic              last;
    logic              commit;
    logic              is_read;
    logic              rd_en;
    logic [DATA_W-1:0] rem_next;
    logic [DATA_W-1:0] quo_next;

    hilo_decode u_dec (
        .valid_i (instr_valid),
        .word_i  (instr),
        .cmd_o   (cmd)
    );

    assign start   = (cmd.op == CMD_DIV);
    assign is_read = (cmd.op == CMD_RD_HI) || (cmd.op == CMD_RD_LO);
    assign rd_en   = is_read && !running;
    assign commit  = last && !start;
    assign busy    = running;

    div_seq #(.STEPS(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .running_o (running),
        .last_o    (last)
    );

    div_step_path #(.W(DATA_W)) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .step_i     (running),
        .dividend_i (rs_data),
        .divisor_i  (rt_data),
        .rem_next_o (rem_next),
        .quo_next_o (quo_next)
    );

    hilo_file #(.W(DATA_W)) u_hilo (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (commit),
        .rem_i      (rem_next),
        .quo_i      (quo_next),
        .rd_en_i    (rd_en),
        .rd_hi_i    (cmd.op == CMD_RD_HI),
        .rd_dest_i  (cmd.dest),
        .wb_valid_o (wb_valid),
        .wb_addr_o  (wb_addr),
        .wb_data_o  (wb_data)
    );

    // R2: an accepted divide makes the unit busy in the next cycle
    a_r2_div_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R7: a read arriving while busy yields no write-back
    a_r7_stall_read: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read && busy) |=> !wb_valid);

    // R6: busy falls only together with a commit of the result
    a_r6_fall_commits: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(commit));

    // R11: a cycle with no decoded read produces no write-back
    a_r11_no_spurious_wb: assert property (@(posedge clk) disable iff (!rst_n)
        !is_read |=> !wb_valid);

endmodule

// File: tb/test_hilo_divider.sv
`timescale 1ns/1ps
module test_hilo_divider;

    localparam int unsigned W = 6;
    localparam int unsigned N = 1 << W;
    localparam logic [W-1:0] ALL1 = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         instr_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic [W-1:0] rs_data = '0;
    logic [W-1:0] rt_data = '0;
    logic         busy;
    logic         wb_valid;
    logic [4:0]   wb_addr;
    logic [W-1:0] wb_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    hilo_divider #(.DATA_W(W)) i_hilo_divider (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr       (instr),
        .rs_data     (rs_data),
        .rt_data     (rt_data),
        .busy        (busy),
        .wb_valid    (wb_valid),
        .wb_addr     (wb_addr),
        .wb_data     (wb_data)
    );

    function automatic logic [31:0] div_word(input logic [4:0] rs, input logic [4:0] rt);
        return {6'h00, rs, rt, 10'h000, 6'h1B};
    endfunction

    function automatic logic [31:0] rd_word(input logic [4:0] rd, input bit hi);
        return {16'h0000, rd, 5'h00, (hi ? 6'h10 : 6'h12)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one word for one clock edge; called and returns at a negedge.
    task automatic drive(input logic [31:0] w, input logic [W-1:0] a, input logic [W-1:0] b);
        instr_valid = 1'b1;
        instr       = w;
        rs_data     = a;
        rt_data     = b;
        @(negedge clk);
        instr_valid = 1'b0;
        instr       = '0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic read_chk(input string req, input bit hi, input logic [4:0] rd, input logic [W-1:0] exp);
        drive(rd_word(rd, hi), '0, '0);
        chk(req, 32'(wb_valid), 32'd1);
        chk(req, 32'(wb_addr), 32'(rd));
        chk(req, 32'(wb_data), 32'(exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 wb_valid", 32'(wb_valid), 32'd0);
        read_chk("R1 LO", 1'b0, 5'd9, '0);
        read_chk("R1 HI", 1'b1, 5'd9, '0);

        // R2/R3: encodings
        chk("R2 word", div_word(5'd8, 5'd7), 32'h0107001B);
        chk("R3 word lo", rd_word(5'd8, 1'b0), 32'h00004012);
        chk("R3 word hi", rd_word(5'd8, 1'b1), 32'h00004010);
        drive(32'h0107001B, W'(45), W'(7));
        chk("R2 busy", 32'(busy), 32'd1);
        wait_idle();
        drive(32'h00004012, '0, '0);
        chk("R3 lo valid", 32'(wb_valid), 32'd1);
        chk("R3 lo addr", 32'(wb_addr), 32'd8);
        chk("R3 lo data", 32'(wb_data), 32'd6);
        drive(32'h00004010, '0, '0);
        chk("R3 hi data", 32'(wb_data), 32'd3);

        // R6: busy window length, then immediate read
        drive(div_word(5'd1, 5'd2), W'(63), W'(5));
        cnt = 0;
        while (busy && cnt < 100) begin cnt++; @(negedge clk); end
        chk("R6 busy cycles", 32'(cnt), 32'(W));
        read_chk("R6 LO", 1'b0, 5'd4, W'(12));

        // R7: read while busy is stalled
        drive(div_word(5'd1, 5'd2), W'(20), W'(3));
        drive(rd_word(5'd4, 1'b0), '0, '0);
        chk("R7 no wb", 32'(wb_valid), 32'd0);
        chk("R7 busy", 32'(busy), 32'd1);
        wait_idle();
        read_chk("R7 LO", 1'b0, 5'd4, W'(6));
        read_chk("R7 HI", 1'b1, 5'd4, W'(2));

        // R8: destination 0 discarded
        drive(rd_word(5'd0, 1'b1), '0, '0);
        chk("R8 no wb", 32'(wb_valid), 32'd0);

        // R9: restart while busy
        drive(div_word(5'd1, 5'd2), W'(50), W'(7));
        @(negedge clk); @(negedge clk);
        drive(div_word(5'd1, 5'd2), W'(45), W'(4));
        cnt = 0;
        while (busy && cnt < 100) begin cnt++; @(negedge clk); end
        chk("R9 busy cycles", 32'(cnt), 32'(W));
        read_chk("R9 LO", 1'b0, 5'd6, W'(11));
        read_chk("R9 HI", 1'b1, 5'd6, W'(1));

        // R10: read then divide on the next cycle
        drive(rd_word(5'd5, 1'b0), '0, '0);
        chk("R10 wb valid", 32'(wb_valid), 32'd1);
        chk("R10 old LO", 32'(wb_data), 32'd11);
        instr_valid = 1'b1; instr = div_word(5'd1, 5'd2);
        rs_data = W'(60); rt_data = W'(9);
        @(negedge clk);
        instr_valid = 1'b0; instr = '0;
        chk("R10 busy", 32'(busy), 32'd1);
        chk("R10 wb ends", 32'(wb_valid), 32'd0);
        wait_idle();
        read_chk("R10 new LO", 1'b0, 5'd5, W'(6));

        // R11: foreign words ignored
        drive(32'h01070019, W'(33), W'(2));
        chk("R11 multu busy", 32'(busy), 32'd0);
        chk("R11 multu wb", 32'(wb_valid), 32'd0);
        drive({6'h08, 5'd8, 5'd7, 10'h000, 6'h1B}, W'(33), W'(2));
        chk("R11 opcode busy", 32'(busy), 32'd0);
        drive(32'h00A04012, '0, '0);
        chk("R11 rs field wb", 32'(wb_valid), 32'd0);
        drive(32'h01070000 | 32'h0000009B, W'(33), W'(2));
        chk("R11 shamt busy", 32'(busy), 32'd0);
        read_chk("R11 LO kept", 1'b0, 5'd7, W'(6));
        read_chk("R11 HI kept", 1'b1, 5'd7, W'(6));

        // R4/R5: exhaustive sweep
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                logic [W-1:0] eq;
                logic [W-1:0] er;
                eq = (b == 0) ? ALL1 : W'(a / b);
                er = (b == 0) ? W'(a) : W'(a % b);
                drive(div_word(5'd3, 5'd4), W'(a), W'(b));
                wait_idle();
                read_chk((b == 0) ? "R5 LO" : "R4 LO", 1'b0, 5'd2, eq);
                read_chk((b == 0) ? "R5 HI" : "R4 HI", 1'b1, 5'd3, er);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule